// File: doc/BRIEF.md
# Protection Region Bound Decoder

This block converts a set of protection-entry programming values into plain inclusive byte-address windows. Each entry supplies an address register, which holds byte-address bits above bit 1, and a 2-bit match mode. For every entry the decoder produces a start bound, an end bound and an active flag. It also reports how many entries are active. A later comparison stage can then test an access against simple `start <= addr <= end` windows, without knowing how each window was encoded.

The logic is purely combinational. Entry *i* reads the address register of entry *i-1* for its top-of-range mode, and entry 0 treats that neighbour as zero. The bounds are two bits wider than the address register. This lets the largest power-of-two windows, up to the whole address space, be represented without overflow. All arithmetic on the bounds wraps modulo 2^(AW+2).

Top module: `prot_region_decoder`

## Requirements
- R1: Mode code 0 (off) drives the entry's active flag low and both of its bounds to zero.
- R2: Mode code 1 (top-of-range) gives start = 4 × (previous entry's register) and end = 4 × (own register) − 1. Entry 0 uses zero as the previous register.
- R3: In top-of-range mode, when the start computed per R2 is greater than the end, both bounds become zero while the entry stays active.
- R4: In top-of-range mode with an own register of zero, the end wraps to 2^(AW+2) − 1.
- R5: Mode code 2 (4-byte window) gives start = 4 × register and end = start + 3.
- R6: Mode code 3 (power-of-two window) with t trailing ones in the register, where t < AW, gives a window of 8·2^t bytes. The window is aligned to its size and contains 4 × register.
- R7: Mode code 3 with an all-ones register covers the whole space, from 0 to 2^(AW+2) − 1.
- R8: Every entry whose mode is not 0 is active, and the active count equals the number of active entries.
- R9: For every active entry, the start is never greater than the end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| region_addr | input | N_ENTRIES*AW | Address registers; entry i occupies bits [i*AW +: AW] |
| region_mode | input | 2*N_ENTRIES | Match modes; entry i occupies bits [2*i +: 2] |
| bound_lo | output | N_ENTRIES*(AW+2) | Inclusive start byte address per entry |
| bound_hi | output | N_ENTRIES*(AW+2) | Inclusive end byte address per entry |
| entry_on | output | N_ENTRIES | Active flag per entry |
| active_total | output | $clog2(N_ENTRIES+1) | Number of active entries |

## Verification
The embedded checks hold at all times. They check that an active window is never inverted, that a 4-byte window spans exactly four bytes, that a power-of-two window has a power-of-two size of at least 8 bytes, that off entries drive zero bounds, and that the count agrees with the flags. Only the bench sweeps can show that the bounds have the right values. These values are the neighbour coupling in top-of-range mode, the collapse and wrap corners, alignment and size per trailing-ones count, and the whole-space encoding. The bench checks them against arithmetic over every register and mode combination of a small configuration.

// File: rtl/prot_region_pkg.sv
// Shared match-mode encoding for the region bound decoder.
// Assumes a 2-bit mode field per entry.
package prot_region_pkg;
    typedef enum logic [1:0] {
        MATCH_OFF   = 2'd0,
        MATCH_TOP   = 2'd1,
        MATCH_QUAD  = 2'd2,
        MATCH_POW2  = 2'd3
    } match_mode_t;
endpackage

// File: rtl/prot_region_entry.sv
// Decodes one entry: turns its address register, its mode and the previous
// entry's register into inclusive byte bounds plus an active flag.
// Assumes bounds are AW+2 bits wide and all arithmetic wraps at that width.
module prot_region_entry
    import prot_region_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0]   own_reg,
    input  logic [AW-1:0]   prev_reg,
    input  logic [1:0]      mode,
    output logic [AW+1:0]   lo,
    output logic [AW+1:0]   hi,
    output logic            on
);
    localparam int BW = AW + 2;

    logic [BW-1:0] own_byte;
    logic [BW-1:0] prev_byte;
    logic [BW-1:0] tor_end;
    logic [BW-1:0] pow_v;

    // Byte-address forms of the registers.
    always_comb begin
        own_byte  = {own_reg, 2'b00};
        prev_byte = {prev_reg, 2'b00};
        tor_end   = own_byte - BW'(1);
        pow_v     = {own_reg, 2'b11};
    end

    // Select bounds according to the match mode.
    always_comb begin
        lo = '0;
        hi = '0;
        on = 1'b1;
        unique case (match_mode_t'(mode))
            MATCH_OFF: begin
                on = 1'b0;
            end
            MATCH_TOP: begin
                if (prev_byte <= tor_end) begin
                    lo = prev_byte;
                    hi = tor_end;
                end
            end
            MATCH_QUAD: begin
                lo = own_byte;
                hi = own_byte + BW'(3);
            end
            MATCH_POW2: begin
                lo = pow_v & (pow_v + BW'(1));
                hi = pow_v | (pow_v + BW'(1));
            end
            default: begin
                on = 1'b0;
            end
        endcase
    end

    logic [BW-1:0] span;

    // Guards on the decoded window.
    always_comb begin
        span = hi - lo;
        p_order_r9: assert (!on || lo <= hi)
            else $error("entry window inverted");
        p_off_zero_r1: assert (mode != 2'd0 || (lo == '0 && hi == '0 && !on))
            else $error("off entry has nonzero bounds");
        p_quad_span_r5: assert (mode != 2'd2 || span == BW'(3))
            else $error("4-byte window wrong size");
        p_pow2_size_r6: assert (mode != 2'd3 || (((span + BW'(1)) & span) == '0 && span >= BW'(7)))
            else $error("power-of-two window malformed");
    end
endmodule

// File: rtl/prot_region_count.sv
// Counts how many active flags are set.
// Assumes N >= 2 so the count is at least 2 bits wide.
module prot_region_count #(
    parameter int N  = 8,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  flags,
    output logic [CW-1:0] total
);
    // Sum the active flags.
    always_comb begin
        total = '0;
        for (int i = 0; i < N; i++) begin
            total = total + {{(CW-1){1'b0}}, flags[i]};
        end
    end
endmodule

// File: rtl/prot_region_decoder.sv
// Top: one decoder per entry, chained so each sees its lower neighbour's
// register, plus the active counter. Purely combinational.
// Assumes N_ENTRIES >= 2 and AW >= 2.
module prot_region_decoder #(
    parameter int N_ENTRIES = 8,
    parameter int AW        = 32,
    localparam int BW       = AW + 2,
    localparam int CW       = $clog2(N_ENTRIES + 1)
) (
    input  logic [N_ENTRIES*AW-1:0] region_addr,
    input  logic [2*N_ENTRIES-1:0]  region_mode,
    output logic [N_ENTRIES*BW-1:0] bound_lo,
    output logic [N_ENTRIES*BW-1:0] bound_hi,
    output logic [N_ENTRIES-1:0]    entry_on,
    output logic [CW-1:0]           active_total
);
    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
        logic [AW-1:0] prev;
        if (g == 0) begin : g_first
            assign prev = '0;
        end else begin : g_rest
            assign prev = region_addr[(g-1)*AW +: AW];
        end
        prot_region_entry #(.AW(AW)) u_entry (
            .own_reg  (region_addr[g*AW +: AW]),
            .prev_reg (prev),
            .mode     (region_mode[2*g +: 2]),
            .lo       (bound_lo[g*BW +: BW]),
            .hi       (bound_hi[g*BW +: BW]),
            .on       (entry_on[g])
        );
    end

    prot_region_count #(.N(N_ENTRIES), .CW(CW)) u_count (
        .flags (entry_on),
        .total (active_total)
    );

    // Count must agree with the flags and never exceed the entry count.
    always_comb begin
        p_count_r8: assert (int'(active_total) == $countones(entry_on) && int'(active_total) <= N_ENTRIES)
            else $error("active count disagrees with flags");
    end
endmodule

// File: tb/tb_prot_region_decoder.sv
module tb_prot_region_decoder;
    localparam int N  = 4;
    localparam int AW = 4;
    localparam int BW = AW + 2;
    localparam int CW = $clog2(N + 1);
    localparam longint SPACE = 64'd1 << BW;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [N*AW-1:0] region_addr;
    logic [2*N-1:0]  region_mode;
    logic [N*BW-1:0] bound_lo, bound_hi;
    logic [N-1:0]    entry_on;
    logic [CW-1:0]   active_total;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    prot_region_decoder #(.N_ENTRIES(N), .AW(AW)) dut (
        .region_addr (region_addr),
        .region_mode (region_mode),
        .bound_lo    (bound_lo),
        .bound_hi    (bound_hi),
        .entry_on    (entry_on),
        .active_total(active_total)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected bounds from arithmetic on the requirements.
    task automatic model(input int mode, input longint a, input longint p,
                         output longint lo, output longint hi, output bit on);
        longint t, size;
        lo = 0; hi = 0; on = (mode != 0);
        case (mode)
            1: begin
                lo = p * 4;
                hi = (a * 4 - 1 + SPACE) % SPACE;
                if (lo > hi) begin lo = 0; hi = 0; end
            end
            2: begin lo = a * 4; hi = a * 4 + 3; end
            3: begin
                t = 0;
                while (t < AW && ((a >> t) & 1) == 1) t++;
                if (t == AW) begin lo = 0; hi = SPACE - 1; end
                else begin
                    size = 64'd8 << t;
                    lo = (a * 4) & ~(size - 1);
                    hi = lo + size - 1;
                end
            end
            default: ;
        endcase
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    function automatic string tag_of(input int mode, input longint a, input longint p);
        if (mode == 0) return "R1";
        if (mode == 2) return "R5";
        if (mode == 3) return (a == (1 << AW) - 1) ? "R7" : "R6";
        if (a == 0) return "R4";
        if (p * 4 > a * 4 - 1) return "R3";
        return "R2";
    endfunction

    initial begin
        longint elo, ehi;
        bit eon;
        region_addr = '0;
        region_mode = '0;
        settle();
        // Reset-like idle state: everything off.
        chk(entry_on == '0, "R1 idle flags", longint'(entry_on), 0);
        chk(active_total == '0, "R8 idle count", longint'(active_total), 0);
        chk(bound_lo == '0 && bound_hi == '0, "R1 idle bounds", longint'(bound_hi), 0);

        // Entry 1 sweep: every mode, own register and neighbour register.
        for (int m = 0; m < 4; m++) begin
            for (int a = 0; a < (1 << AW); a++) begin
                for (int p = 0; p < (1 << AW); p++) begin
                    @(posedge clk);
                    region_addr = '0;
                    region_addr[0 +: AW]  = AW'(p);
                    region_addr[AW +: AW] = AW'(a);
                    region_mode = '0;
                    region_mode[2 +: 2] = 2'(m);
                    settle();
                    model(m, a, p, elo, ehi, eon);
                    chk(longint'(bound_lo[BW +: BW]) == elo, {tag_of(m, a, p), " lo"}, longint'(bound_lo[BW +: BW]), elo);
                    chk(longint'(bound_hi[BW +: BW]) == ehi, {tag_of(m, a, p), " hi"}, longint'(bound_hi[BW +: BW]), ehi);
                    chk(entry_on[1] == eon, "R8 flag", longint'(entry_on[1]), longint'(eon));
                    chk(!eon || bound_lo[BW +: BW] <= bound_hi[BW +: BW], "R9 order", longint'(bound_lo[BW +: BW]), longint'(bound_hi[BW +: BW]));
                end
            end
        end

        // Entry 0 in top-of-range mode sees a zero neighbour (R2), even with the top entry's register set.
        for (int a = 0; a < (1 << AW); a++) begin
            @(posedge clk);
            region_addr = '1;
            region_addr[0 +: AW] = AW'(a);
            region_mode = '0;
            region_mode[0 +: 2] = 2'd1;
            settle();
            model(1, a, 0, elo, ehi, eon);
            chk(longint'(bound_lo[0 +: BW]) == elo, "R2 entry0 lo", longint'(bound_lo[0 +: BW]), elo);
            chk(longint'(bound_hi[0 +: BW]) == ehi, "R2 entry0 hi", longint'(bound_hi[0 +: BW]), ehi);
        end

        // Count over every mode combination (R8).
        for (int c = 0; c < (1 << (2 * N)); c++) begin
            int exp_n;
            @(posedge clk);
            region_addr = '0;
            region_mode = (2*N)'(c);
            settle();
            exp_n = 0;
            for (int k = 0; k < N; k++) if (((c >> (2 * k)) & 3) != 0) exp_n++;
            chk(int'(active_total) == exp_n, "R8 count", longint'(active_total), exp_n);
            for (int k = 0; k < N; k++)
                chk(entry_on[k] == (((c >> (2 * k)) & 3) != 0), "R8 flag each", longint'(entry_on[k]), longint'(((c >> (2 * k)) & 3) != 0));
        end
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule